// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst on a synchronous cache memory. A burst begins when either of two address strobes is high at a rising clock edge. One strobe belongs to the processor and the other to the cache controller. On that edge the block captures the presented address. Each later edge with the advance input high moves the burst one beat forward. The two low address bits follow the beat order, and the upper bits stay at the captured value.

A single order input is sampled together with the start address. When it is low, the beats run in wrapping linear order. When it is high, they run in interleaved order, where the low bits are the start bits XORed with the beat number. The order then stays fixed until the next strobe. The output is a register, so the address for a beat appears on the clock edge that creates that beat. All control pins are plain levels with no handshake. The block always takes every strobe and advance, so it applies no back-pressure.

Top module: `bas_burst_seq`

## Requirements
- R1: While reset is low, and on the first edge after it is released with no strobe or advance, `word_addr` is all zeros.
- R2: At a rising edge where `proc_strobe` or `ctrl_strobe` is high, `word_addr` becomes `addr_in`. Either strobe alone is enough.
- R3: When the order input was low at the starting strobe, each advance edge adds one to bits [1:0] of `word_addr`, modulo 4. For example, start 2 gives 2, 3, 0, 1.
- R4: When the order input was high at the starting strobe, bits [1:0] equal the start bits XOR the beat number. The beat number is 0 at the strobe and rises by one on each advance. For example, start 1 gives 1, 0, 3, 2, and start 2 gives 2, 3, 0, 1.
- R5: Bits [ADDR_W-1:2] of `word_addr` change only on a strobe edge, where they take the upper bits of `addr_in`.
- R6: A strobe takes priority over `advance` on the same edge. A strobe in the middle of a burst reloads the address and resets the beat number to 0.
- R7: On an edge with no strobe and `advance` low, `word_addr` keeps its value.
- R8: The order input is ignored on edges without a strobe. Changing it mid-burst does not alter the beat sequence.
- R9: The beat number wraps. After four advances, `word_addr` returns to the start address, and further advances repeat the same sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strobe | input | 1 | Processor address strobe; starts a burst |
| ctrl_strobe | input | 1 | Cache-controller address strobe; starts a burst |
| advance | input | 1 | Steps the burst one beat |
| interleave | input | 1 | Beat order sampled at a strobe: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | Start word address |
| word_addr | output | ADDR_W | Registered word address of the current beat |

## Verification
The bound checker checks, on every cycle, how the output changes edge to edge. It covers the load on either strobe and the priority of a strobe over advance. It also covers the hold when the block is idle, the frozen upper bits, and the linear and interleaved low-bit steps against the order captured at the strobe. The bench's directed and random scenarios show what needs a whole sequence to see. That includes the full example orders, the return to the start address after four advances, and the order input having no effect mid-burst. It also includes the reset value.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bas_capture.sv
module bas_capture
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter bit ORDER_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              order_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_nxt,
  output order_e            order_nxt
);
  logic [ADDR_W-1:0] base_q;
  order_e            order_q;

  always_comb begin
    base_nxt  = base_q;
    order_nxt = order_q;
    if (load) begin
      base_nxt  = addr_in;
      order_nxt = order_e'(order_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= order_e'(ORDER_RST);
    end else begin
      base_q  <= base_nxt;
      order_q <= order_nxt;
    end
  end
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_nxt
);
  logic [BEAT_W-1:0] beat_q;

  always_comb begin
    if (load)      beat_nxt = '0;
    else if (step) beat_nxt = beat_q + BEAT_W'(1);
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_nxt;
  end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] lo_out
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = start_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  assign lo_out = (order == ORD_INTERLEAVE) ? xor_lo : lin_lo;
endmodule

// File: rtl/bas_burst_seq.sv
module bas_burst_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2,
  parameter bit ORDER_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base_nxt;
  order_e            order_nxt;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] lo_nxt;
  logic [ADDR_W-1:0] addr_q;

  assign load = proc_strobe | ctrl_strobe;

  bas_capture #(.ADDR_W(ADDR_W), .ORDER_RST(ORDER_RST)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .order_in (interleave),
    .addr_in  (addr_in),
    .base_nxt (base_nxt),
    .order_nxt(order_nxt)
  );

  bas_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (advance),
    .beat_nxt(beat_nxt)
  );

  bas_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo(base_nxt[BEAT_W-1:0]),
    .beat    (beat_nxt),
    .order   (order_nxt),
    .lo_out  (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= {base_nxt[ADDR_W-1:ADDR_W-HI_W], lo_nxt};
  end

  assign word_addr = addr_q;
endmodule

// File: rtl/bas_burst_seq_chk.sv
module bas_burst_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2,
  parameter bit ORDER_RST = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strobe,
  input logic              ctrl_strobe,
  input logic              advance,
  input logic              interleave,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] word_addr
);
  logic              strobe;
  logic [BEAT_W-1:0] c_start;
  logic [BEAT_W-1:0] c_beat;
  logic              c_ilv;

  assign strobe = proc_strobe | ctrl_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_start <= '0;
      c_beat  <= '0;
      c_ilv   <= ORDER_RST;
    end else if (strobe) begin
      c_start <= addr_in[BEAT_W-1:0];
      c_beat  <= '0;
      c_ilv   <= interleave;
    end else if (advance) begin
      c_beat  <= c_beat + BEAT_W'(1);
    end
  end

  // R2 R6
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> word_addr == $past(addr_in));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !advance) |=> $stable(word_addr));

  // R5
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && advance && !c_ilv) |=>
      word_addr[BEAT_W-1:0] == BEAT_W'($past(word_addr[BEAT_W-1:0]) + BEAT_W'(1)));

  // R4 R8
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && advance && c_ilv) |=>
      word_addr[BEAT_W-1:0] == (c_start ^ c_beat));
endmodule

bind bas_burst_seq bas_burst_seq_chk #(
  .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .ORDER_RST(ORDER_RST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .proc_strobe(proc_strobe),
  .ctrl_strobe(ctrl_strobe),
  .advance    (advance),
  .interleave (interleave),
  .addr_in    (addr_in),
  .word_addr  (word_addr)
);

// File: tb/bas_burst_seq_test.sv
module bas_burst_seq_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_strobe = 1'b0;
  logic          ctrl_strobe = 1'b0;
  logic          advance = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] word_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_ilv = 1'b1;

  always #4 clk = ~clk;

  bas_burst_seq #(.ADDR_W(AW), .BEAT_W(2), .ORDER_RST(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe),
    .advance(advance), .interleave(interleave), .addr_in(addr_in), .word_addr(word_addr)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, logic [1:0] n, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ n) : (b[1:0] + n);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: word_addr=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic ps, input logic cs, input logic adv,
                     input logic md, input logic [AW-1:0] a, input string req);
    proc_strobe = ps; ctrl_strobe = cs; advance = adv; interleave = md; addr_in = a;
    @(posedge clk);
    if (ps || cs) begin
      m_base = a; m_beat = 2'd0; m_ilv = md;
    end else if (adv) begin
      m_beat = m_beat + 2'd1;
    end
    #2;
    check(req, word_addr, expect_addr(m_base, m_beat, m_ilv));
  endtask

  task automatic check_lo(string req, logic [1:0] exp);
    checks++;
    if (word_addr[1:0] !== exp) begin
      fails++;
      $display("FAIL %s: low=%0d expected=%0d at %0t", req, word_addr[1:0], exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", word_addr, '0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 16'h1234, "R1 idle after reset");
    check("R1 value", word_addr, '0);

    // R3 linear from 2: 2,3,0,1
    cyc(1, 0, 0, 0, 16'hA5A2, "R2 proc load");
    check("R2 addr", word_addr, 16'hA5A2);
    cyc(0, 0, 1, 0, '0, "R3"); check_lo("R3 beat1", 2'd3);
    cyc(0, 0, 1, 0, '0, "R3"); check_lo("R3 beat2", 2'd0);
    cyc(0, 0, 1, 0, '0, "R3"); check_lo("R3 beat3", 2'd1);
    // R9 wrap back to start
    cyc(0, 0, 1, 0, '0, "R9"); check("R9 wrap", word_addr, 16'hA5A2);
    check("R5 upper", {word_addr[AW-1:2], 2'b00}, 16'hA5A0);

    // R4 interleaved from 1: 1,0,3,2
    cyc(0, 1, 0, 1, 16'h0F01, "R2 ctrl load");
    check("R2 ctrl addr", word_addr, 16'h0F01);
    cyc(0, 0, 1, 1, '0, "R4"); check_lo("R4 beat1", 2'd0);
    cyc(0, 0, 1, 0, '0, "R8"); check_lo("R4 R8 beat2", 2'd3);
    cyc(0, 0, 1, 0, '0, "R8"); check_lo("R4 R8 beat3", 2'd2);
    cyc(0, 0, 1, 1, '0, "R9"); check_lo("R9 ilv wrap", 2'd1);

    // R7 hold
    held = word_addr;
    cyc(0, 0, 0, 0, 16'hFFFF, "R7");
    cyc(0, 0, 0, 1, 16'h7777, "R7");
    check("R7 hold", word_addr, held);

    // R6 mid-burst reload with advance also high
    cyc(1, 0, 0, 1, 16'h3332, "R6");
    cyc(0, 0, 1, 1, '0, "R6");
    cyc(0, 1, 1, 0, 16'h4441, "R6 ctrl+adv");
    check("R6 reload", word_addr, 16'h4441);
    cyc(0, 0, 1, 1, '0, "R6 R8"); check_lo("R6 beat restart", 2'd2);
    cyc(1, 1, 1, 1, 16'h8883, "R6 both strobes");
    check("R6 both", word_addr, 16'h8883);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic ps, cs, adv, md;
      ps  = ($urandom_range(0, 7) == 0);
      cs  = ($urandom_range(0, 7) == 0);
      adv = ($urandom_range(0, 1) == 1);
      md  = $urandom_range(0, 1) == 1;
      cyc(ps, cs, adv, md, AW'($urandom), "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    finish_run();
  end
endmodule